// File: doc/BRIEF.md
# Byte Device Transfer Unit

This unit executes the three device instructions of a processor whose accumulator A is 24 bits wide: probe a device, read one byte from it, and write one byte to it. The instruction carries an 8-bit device code. The unit decodes that code onto one of `DEV_CNT` byte channels, and each channel uses a valid/ready handshake. Every transfer moves a single byte through the low eight bits of A.

A probe completes in one cycle. It posts a two-bit condition code that later conditional branches can test. A read or a write to a present device holds `busy` high until the device completes the handshake, which stalls the processor. A read then returns a new accumulator value with only the low byte replaced. A write presents the low byte of A, captured when the instruction was issued, and keeps it stable until the device accepts it. Codes at or above `DEV_CNT` select no device.

Top module: `bytedev_unit`

## Requirements
- R1: During and after reset `busy`, `done`, `acc_we` and `cc_we` are low, and no bit of `dev_rx_ready` or `dev_tx_valid` is high. This also applies when reset is asserted while a transfer is in progress.
- R2: A probe (`op_kind` = 2'b01) of a present device whose `dev_rx_valid` or `dev_tx_ready` bit is high at the accepting edge makes `cc_we` and `done` pulse in the next cycle, with `cc_out` = 2'b01 (less).
- R3: A probe of a present device with both of those bits low, or of a code at or above `DEV_CNT`, posts `cc_out` = 2'b00 (equal). A probe never raises `acc_we`.
- R4: A read (`op_kind` = 2'b10) of a present device raises only that device's `dev_rx_ready` bit. In the cycle after the edge at which `dev_rx_valid` is also high, `acc_out` equals A[23:8] captured at issue joined with the device byte, and `acc_we` and `done` pulse.
- R5: A write (`op_kind` = 2'b11) raises only the addressed `dev_tx_valid` bit. `dev_tx_data` holds A[7:0] captured at issue and stays stable until the edge at which `dev_tx_ready` is high. In the next cycle `done` pulses and `acc_we` stays low.
- R6: `busy` is high from the cycle after a read or write to a present device is accepted until the handshake completes. Operations presented while `busy` is high are ignored.
- R7: A read or write to a code at or above `DEV_CNT` raises no handshake line, leaves `busy` low and `acc_we` low, and pulses `done` in the next cycle.
- R8: `op_kind` = 2'b00 is no operation: it produces no `done`, no `cc_we`, no `acc_we` and no `busy`.
- R9: `cc_we` pulses only for probes and `acc_we` only for reads, and each coincides with `done`.
- R10: At most one bit across `dev_rx_ready` and `dev_tx_valid` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction is presented |
| op_kind | input | 2 | 00 none, 01 probe, 10 read, 11 write |
| op_dev | input | 8 | Device code |
| acc_in | input | ACC_W | Current accumulator value |
| busy | output | 1 | Transfer waiting on a device; stall the processor |
| done | output | 1 | One-cycle completion pulse |
| acc_we | output | 1 | Accumulator write enable (reads) |
| acc_out | output | ACC_W | New accumulator value |
| cc_we | output | 1 | Condition-code write enable (probes) |
| cc_out | output | 2 | Condition code: 01 less, 00 equal, 10 greater |
| dev_rx_valid | input | DEV_CNT | Per-device: a byte is offered |
| dev_rx_data | input | DEV_CNT*8 | Per-device offered byte, device i at bits 8i+7:8i |
| dev_rx_ready | output | DEV_CNT | Per-device: byte taken |
| dev_tx_valid | output | DEV_CNT | Per-device: byte presented |
| dev_tx_data | output | 8 | Shared outgoing byte |
| dev_tx_ready | input | DEV_CNT | Per-device: byte accepted |

## Verification
The checker assumes the devices obey the handshake rules. A device holds its offered byte steady while `dev_rx_valid` is high, and it does not need `dev_rx_ready` before it raises `dev_rx_valid`. It also assumes `op_kind` and `op_dev` are steady whenever `op_valid` is high at an edge. The bench changes device inputs only at falling edges. It raises a device's valid or ready bit only while that device is addressed, and it drops the bit right after the completing edge. While a transfer waits, the bench alters `acc_in` to show that the values captured at issue are the ones used.

// File: rtl/bytedev_pkg.sv
package bytedev_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CODE_W = 8;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_PROBE = 2'b01,
      OP_READ  = 2'b10,
      OP_WRITE = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      CC_EQ = 2'b00,
      CC_LT = 2'b01,
      CC_GT = 2'b10
   } cc_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } st_e;
endpackage

// File: rtl/bytedev_decode.sv
module bytedev_decode
   import bytedev_pkg::*;
#(
   parameter int unsigned DEV_CNT = 4
) (
   input  logic [CODE_W-1:0]  code,
   output logic [DEV_CNT-1:0] sel,
   output logic               mapped
);
   // One comparator per present device; codes beyond DEV_CNT match nothing.
   for (genvar g = 0; g < DEV_CNT; g++) begin : g_cmp
      assign sel[g] = (code == CODE_W'(g));
   end

   assign mapped = |sel;
endmodule

// File: rtl/bytedev_mux.sv
module bytedev_mux
   import bytedev_pkg::*;
#(
   parameter int unsigned DEV_CNT = 4
) (
   input  logic [DEV_CNT-1:0]        sel,
   input  logic [DEV_CNT-1:0]        rx_valid,
   input  logic [DEV_CNT*BYTE_W-1:0] rx_data,
   input  logic [DEV_CNT-1:0]        tx_ready,
   output logic                      sel_rx_valid,
   output logic [BYTE_W-1:0]         sel_rx_data,
   output logic                      sel_tx_ready
);
   logic [BYTE_W-1:0] masked [DEV_CNT];

   // AND-OR selection: each lane is gated by its select bit, then all lanes are ORed.
   for (genvar g = 0; g < DEV_CNT; g++) begin : g_lane
      assign masked[g] = rx_data[g*BYTE_W +: BYTE_W] & {BYTE_W{sel[g]}};
   end

   always_comb begin
      sel_rx_data = '0;
      for (int i = 0; i < DEV_CNT; i++) begin
         sel_rx_data = sel_rx_data | masked[i];
      end
   end

   assign sel_rx_valid = |(rx_valid & sel);
   assign sel_tx_ready = |(tx_ready & sel);
endmodule

// File: rtl/bytedev_ctrl.sv
module bytedev_ctrl
   import bytedev_pkg::*;
#(
   parameter int unsigned ACC_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_kind,
   input  logic [CODE_W-1:0] op_dev,
   input  logic [ACC_W-1:0]  acc_in,
   input  logic              mapped,
   input  logic              sel_rx_valid,
   input  logic [BYTE_W-1:0] sel_rx_data,
   input  logic              sel_tx_ready,
   output logic [CODE_W-1:0] code_q,
   output logic              busy,
   output logic              rd_act,
   output logic              wr_act,
   output logic              done,
   output logic              acc_we,
   output logic [ACC_W-1:0]  acc_out,
   output logic              cc_we,
   output logic [1:0]        cc_out,
   output logic [BYTE_W-1:0] tx_byte
);
   localparam int unsigned HI_W = ACC_W - BYTE_W;

   st_e             st_q;
   op_e             kind_q;
   logic [HI_W-1:0] hi_q;
   op_e             kind_in;

   assign kind_in = op_e'(op_kind);
   assign busy    = (st_q == ST_XFER);
   assign rd_act  = busy && (kind_q == OP_READ);
   assign wr_act  = busy && (kind_q == OP_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= OP_NONE;
         code_q  <= '0;
         hi_q    <= '0;
         tx_byte <= '0;
         done    <= 1'b0;
         acc_we  <= 1'b0;
         acc_out <= '0;
         cc_we   <= 1'b0;
         cc_out  <= CC_EQ;
      end else begin
         done   <= 1'b0;
         acc_we <= 1'b0;
         cc_we  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (op_valid) begin
                  unique case (kind_in)
                     OP_PROBE: begin
                        cc_out <= (mapped && (sel_rx_valid || sel_tx_ready)) ? CC_LT : CC_EQ;
                        cc_we  <= 1'b1;
                        done   <= 1'b1;
                     end
                     OP_READ, OP_WRITE: begin
                        if (mapped) begin
                           st_q    <= ST_XFER;
                           kind_q  <= kind_in;
                           code_q  <= op_dev;
                           hi_q    <= acc_in[ACC_W-1:BYTE_W];
                           tx_byte <= acc_in[BYTE_W-1:0];
                        end else begin
                           done <= 1'b1;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_XFER: begin
               if (kind_q == OP_READ && sel_rx_valid) begin
                  acc_out <= {hi_q, sel_rx_data};
                  acc_we  <= 1'b1;
                  done    <= 1'b1;
                  st_q    <= ST_IDLE;
               end else if (kind_q == OP_WRITE && sel_tx_ready) begin
                  done <= 1'b1;
                  st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bytedev_unit.sv
module bytedev_unit
   import bytedev_pkg::*;
#(
   parameter int unsigned DEV_CNT = 4,
   parameter int unsigned ACC_W   = 24
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      op_valid,
   input  logic [1:0]                op_kind,
   input  logic [7:0]                op_dev,
   input  logic [ACC_W-1:0]          acc_in,
   output logic                      busy,
   output logic                      done,
   output logic                      acc_we,
   output logic [ACC_W-1:0]          acc_out,
   output logic                      cc_we,
   output logic [1:0]                cc_out,
   input  logic [DEV_CNT-1:0]        dev_rx_valid,
   input  logic [DEV_CNT*8-1:0]      dev_rx_data,
   output logic [DEV_CNT-1:0]        dev_rx_ready,
   output logic [DEV_CNT-1:0]        dev_tx_valid,
   output logic [7:0]                dev_tx_data,
   input  logic [DEV_CNT-1:0]        dev_tx_ready
);
   localparam int unsigned MAX_DEV = 1 << CODE_W;

   if (DEV_CNT < 1 || DEV_CNT > MAX_DEV) begin : g_bad_cnt
      $error("bytedev_unit: DEV_CNT must lie in 1..256");
   end
   if (ACC_W <= BYTE_W) begin : g_bad_acc
      $error("bytedev_unit: ACC_W must exceed the byte width");
   end

   logic [CODE_W-1:0]  code_q;
   logic [CODE_W-1:0]  code_sel;
   logic [DEV_CNT-1:0] sel;
   logic               mapped;
   logic               sel_rx_valid;
   logic [BYTE_W-1:0]  sel_rx_data;
   logic               sel_tx_ready;
   logic               rd_act;
   logic               wr_act;

   // While a transfer waits, the captured code steers the channel; otherwise the live code does.
   assign code_sel = busy ? code_q : op_dev;

   bytedev_decode #(.DEV_CNT(DEV_CNT)) i_decode (
      .code   (code_sel),
      .sel    (sel),
      .mapped (mapped)
   );

   bytedev_mux #(.DEV_CNT(DEV_CNT)) i_mux (
      .sel          (sel),
      .rx_valid     (dev_rx_valid),
      .rx_data      (dev_rx_data),
      .tx_ready     (dev_tx_ready),
      .sel_rx_valid (sel_rx_valid),
      .sel_rx_data  (sel_rx_data),
      .sel_tx_ready (sel_tx_ready)
   );

   bytedev_ctrl #(.ACC_W(ACC_W)) i_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .op_kind      (op_kind),
      .op_dev       (op_dev),
      .acc_in       (acc_in),
      .mapped       (mapped),
      .sel_rx_valid (sel_rx_valid),
      .sel_rx_data  (sel_rx_data),
      .sel_tx_ready (sel_tx_ready),
      .code_q       (code_q),
      .busy         (busy),
      .rd_act       (rd_act),
      .wr_act       (wr_act),
      .done         (done),
      .acc_we       (acc_we),
      .acc_out      (acc_out),
      .cc_we        (cc_we),
      .cc_out       (cc_out),
      .tx_byte      (dev_tx_data)
   );

   assign dev_rx_ready = sel & {DEV_CNT{rd_act}};
   assign dev_tx_valid = sel & {DEV_CNT{wr_act}};
endmodule

// File: rtl/bytedev_chk.sv
module bytedev_chk #(
   parameter int unsigned DEV_CNT = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 done,
   input logic                 acc_we,
   input logic [7:0]           acc_lo,
   input logic                 cc_we,
   input logic [DEV_CNT-1:0]   dev_rx_valid,
   input logic [DEV_CNT*8-1:0] dev_rx_data,
   input logic [DEV_CNT-1:0]   dev_rx_ready,
   input logic [DEV_CNT-1:0]   dev_tx_valid,
   input logic [7:0]           dev_tx_data,
   input logic [DEV_CNT-1:0]   dev_tx_ready
);
   logic       rx_hs;
   logic       tx_hs;
   logic [7:0] hs_byte;

   assign rx_hs = |(dev_rx_valid & dev_rx_ready);
   assign tx_hs = |(dev_tx_valid & dev_tx_ready);

   always_comb begin
      hs_byte = '0;
      for (int i = 0; i < DEV_CNT; i++) begin
         if (dev_rx_ready[i]) hs_byte = dev_rx_data[i*8 +: 8];
      end
   end

   AST_HS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_rx_ready, dev_tx_valid})); // R10
   AST_HS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (|{dev_rx_ready, dev_tx_valid}) |-> busy); // R6
   AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dev_tx_valid) && !tx_hs) |=> ((|dev_tx_valid) && $stable(dev_tx_data))); // R5
   AST_RD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hs |=> (acc_we && done && !busy)); // R4
   AST_RD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hs |=> (acc_lo == $past(hs_byte))); // R4
   AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_hs |=> (done && !acc_we && !busy)); // R5
   AST_ACCWE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we |-> (done && !cc_we)); // R9
   AST_CCWE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cc_we |-> (done && !acc_we)); // R9
endmodule

bind bytedev_unit bytedev_chk #(.DEV_CNT(DEV_CNT)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .acc_we       (acc_we),
   .acc_lo       (acc_out[7:0]),
   .cc_we        (cc_we),
   .dev_rx_valid (dev_rx_valid),
   .dev_rx_data  (dev_rx_data),
   .dev_rx_ready (dev_rx_ready),
   .dev_tx_valid (dev_tx_valid),
   .dev_tx_data  (dev_tx_data),
   .dev_tx_ready (dev_tx_ready)
);

// File: tb/test_bytedev_unit.sv
module test_bytedev_unit;
   localparam int N = 4;
   localparam int AW = 24;
   localparam logic [1:0] K_NONE = 2'b00, K_PROBE = 2'b01, K_READ = 2'b10, K_WRITE = 2'b11;
   localparam logic [1:0] C_EQ = 2'b00, C_LT = 2'b01;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [1:0]      op_kind = '0;
   logic [7:0]      op_dev = '0;
   logic [AW-1:0]   acc_in = '0;
   logic            busy, done, acc_we, cc_we;
   logic [AW-1:0]   acc_out;
   logic [1:0]      cc_out;
   logic [N-1:0]    dev_rx_valid = '0;
   logic [N*8-1:0]  dev_rx_data = '0;
   logic [N-1:0]    dev_rx_ready;
   logic [N-1:0]    dev_tx_valid;
   logic [7:0]      dev_tx_data;
   logic [N-1:0]    dev_tx_ready = '0;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bytedev_unit #(.DEV_CNT(N), .ACC_W(AW)) i_bytedev_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_dev(op_dev),
      .acc_in(acc_in), .busy(busy), .done(done), .acc_we(acc_we), .acc_out(acc_out),
      .cc_we(cc_we), .cc_out(cc_out), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
      .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
      .dev_tx_ready(dev_tx_ready)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  dev;
      logic [23:0] acc;
      logic [7:0]  dbyte;
      logic [3:0]  delay;
      logic [1:0]  stat;   // 0 none, 1 device offers a byte, 2 device can accept
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{K_PROBE, 8'd1,   24'h000000, 8'h00, 4'd0, 2'd1},
      '{K_PROBE, 8'd2,   24'h000000, 8'h00, 4'd0, 2'd2},
      '{K_PROBE, 8'd3,   24'h000000, 8'h00, 4'd0, 2'd0},
      '{K_PROBE, 8'd9,   24'h000000, 8'h00, 4'd0, 2'd1},
      '{K_READ,  8'd0,   24'hA5B6C7, 8'h3C, 4'd0, 2'd0},
      '{K_READ,  8'd3,   24'h123456, 8'hFF, 4'd3, 2'd0},
      '{K_WRITE, 8'd2,   24'hABCDEF, 8'h00, 4'd2, 2'd0},
      '{K_WRITE, 8'd0,   24'h00007E, 8'h00, 4'd0, 2'd0},
      '{K_READ,  8'd200, 24'h55AA55, 8'h77, 4'd0, 2'd0},
      '{K_WRITE, 8'd4,   24'h010203, 8'h00, 4'd0, 2'd0},
      '{K_NONE,  8'd1,   24'h000000, 8'h00, 4'd0, 2'd0}
   };

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 5000);
         finish_run();
      end
   end

   task automatic run_vec(input vec_t v);
      int d;
      bit m;
      d = int'(v.dev);
      m = (d < N);
      @(negedge clk);
      op_valid = 1'b1; op_kind = v.kind; op_dev = v.dev; acc_in = v.acc;
      if (m && v.stat == 2'd1) dev_rx_valid[d] = 1'b1;
      if (m && v.stat == 2'd2) dev_tx_ready[d] = 1'b1;
      @(negedge clk);
      op_valid = 1'b0; dev_rx_valid = '0; dev_tx_ready = '0;
      case (v.kind)
         K_PROBE: begin
            check(m && v.stat != 0 ? "R2" : "R3", "cc_out", 32'(cc_out),
                  32'((m && v.stat != 0) ? C_LT : C_EQ));
            check("R2", "cc_we", 32'(cc_we), 32'd1);
            check("R3", "acc_we on probe", 32'(acc_we), 32'd0);
         end
         K_READ: begin
            if (m) begin
               check("R6", "busy after read issue", 32'(busy), 32'd1);
               check("R4", "rx_ready mask", 32'(dev_rx_ready), 32'(1 << d));
               acc_in = ~v.acc;
               for (int k = 0; k < int'(v.delay); k++) begin
                  @(negedge clk);
                  check("R6", "busy while waiting", 32'(busy), 32'd1);
               end
               dev_rx_data[d*8 +: 8] = v.dbyte;
               dev_rx_valid[d] = 1'b1;
               @(negedge clk);
               dev_rx_valid = '0;
               check("R4", "acc_out", 32'(acc_out), 32'({v.acc[23:8], v.dbyte}));
               check("R4", "acc_we", 32'(acc_we), 32'd1);
               check("R9", "cc_we on read", 32'(cc_we), 32'd0);
               check("R6", "busy after read", 32'(busy), 32'd0);
            end else begin
               check("R7", "done unmapped read", 32'(done), 32'd1);
               check("R7", "acc_we unmapped read", 32'(acc_we), 32'd0);
               check("R7", "busy unmapped read", 32'(busy), 32'd0);
               check("R7", "rx_ready unmapped", 32'(dev_rx_ready), 32'd0);
            end
         end
         K_WRITE: begin
            if (m) begin
               check("R5", "tx_valid mask", 32'(dev_tx_valid), 32'(1 << d));
               acc_in = ~v.acc;
               for (int k = 0; k < int'(v.delay); k++) begin
                  @(negedge clk);
                  check("R5", "tx_data held", 32'(dev_tx_data), 32'(v.acc[7:0]));
               end
               check("R5", "tx_data", 32'(dev_tx_data), 32'(v.acc[7:0]));
               dev_tx_ready[d] = 1'b1;
               @(negedge clk);
               dev_tx_ready = '0;
               check("R5", "done after write", 32'(done), 32'd1);
               check("R9", "acc_we on write", 32'(acc_we), 32'd0);
               check("R6", "busy after write", 32'(busy), 32'd0);
            end else begin
               check("R7", "done unmapped write", 32'(done), 32'd1);
               check("R7", "tx_valid unmapped", 32'(dev_tx_valid), 32'd0);
               check("R7", "busy unmapped write", 32'(busy), 32'd0);
            end
         end
         default: begin
            check("R8", "done on none", 32'(done), 32'd0);
            check("R8", "cc_we on none", 32'(cc_we), 32'd0);
            check("R8", "acc_we/busy on none", 32'({acc_we, busy}), 32'd0);
         end
      endcase
      @(negedge clk);
      check("R9", "done is one pulse", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "outputs in reset", 32'({busy, done, acc_we, cc_we}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs after reset", 32'({busy, done, acc_we, cc_we}), 32'd0);
      check("R1", "handshake lines after reset", 32'({dev_rx_ready, dev_tx_valid}), 32'd0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R6: an operation presented while busy is ignored.
      @(negedge clk);
      op_valid = 1'b1; op_kind = K_READ; op_dev = 8'd1; acc_in = 24'h0F0E0D;
      @(negedge clk);
      op_kind = K_PROBE; op_dev = 8'd0; dev_tx_ready[0] = 1'b1;
      @(negedge clk);
      op_valid = 1'b0; dev_tx_ready = '0;
      check("R6", "probe ignored while busy", 32'({cc_we, done}), 32'd0);
      check("R6", "read still pending", 32'(dev_rx_ready), 32'd2);
      dev_rx_data[15:8] = 8'h99; dev_rx_valid[1] = 1'b1;
      @(negedge clk);
      dev_rx_valid = '0;
      check("R6", "read result after ignored op", 32'(acc_out), 32'h0F0E99);

      // R1: reset while a write waits.
      op_valid = 1'b1; op_kind = K_WRITE; op_dev = 8'd3; acc_in = 24'h000042;
      @(negedge clk);
      op_valid = 1'b0;
      check("R5", "write pending before reset", 32'(dev_tx_valid), 32'd8);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "reset mid-transfer", 32'({busy, dev_tx_valid}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "quiet after mid reset", 32'({busy, done, dev_rx_ready, dev_tx_valid}), 32'd0);

      finish_run();
   end
endmodule